// File: doc/BRIEF.md
# Bridge Cycle Claim and Delayed-Retry Controller

This block sits between the two buses of a two-sided bus bridge and settles, for every address phase seen on either side, whether the bridge takes the cycle. Each side supplies a one-cycle address strobe, a pre-decoded target location, the address and command, a flag saying whether the cycle may be posted, and a sense line showing that another fast or medium decode device on that same bus has already claimed it. Side index 0 is the primary bus and side index 1 is the secondary bus. The block answers one cycle after the strobe with a device-select indication, one termination code, and, when the cycle must cross, a forward request toward the opposite bus.

A cycle that crosses and can be posted completes at once. One that cannot be posted is retried. Its address and command are held in a single delayed-transaction slot for that direction, and it is sent across once. After the far side reports that the cycle has finished, the initiator's repeat of the same cycle completes normally and frees the slot. Window decoding, data storage and electrical bus timing sit outside this block.

Top module: `xbc_claim_top`

## Requirements
- R1: A primary-side (index 0) cycle whose location code is far (2'b10), with no peer claim, raises devsel[0] and fwd_req[0] one cycle after cyc_vld[0], and fwd_addr[0] and fwd_cmd[0] carry that cycle's address and command.
- R2: The same holds for the secondary side (index 1): devsel[1] is raised, and fwd_req[1] sends the cycle toward the primary bus.
- R3: A claimed cycle with cyc_post high ends with trm_ok and fwd_posted high, even while the delayed slot of that side is busy.
- R4: A claimed non-postable cycle that finds the slot free ends with trm_retry and issues exactly one forward with fwd_posted low.
- R5: While the slot waits for far-side completion, every claimed non-postable cycle ends with trm_retry and issues no forward, whatever its address.
- R6: After fwd_done for that side, a repeat whose address and command both match the captured cycle ends with trm_ok and no forward, and it frees the slot. The next non-postable cycle is then forwarded again.
- R7: After completion, a non-postable cycle that differs in address or command ends with trm_retry and leaves the slot holding the original cycle.
- R8: A cycle with location own (2'b01) gets trm_none, no devsel and no forward.
- R9: A primary cycle with location neither (2'b00) gets trm_none and raises mabort for one cycle. A secondary cycle with location neither gets trm_none and no mabort.
- R10: When peer_devsel is high with the strobe, the cycle gets trm_none, no devsel and no forward.
- R11: Exactly one of trm_ok, trm_retry, trm_none is high in the cycle after each strobe. All three are low in any cycle that follows no strobe.
- R12: A fwd_done pulse while the slot is free has no effect. After reset all outputs are low and both slots are free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_vld | input | 2 | Address-phase strobe, one per side |
| cyc_loc | input | 2x2 | Decoded target location per side: 00 neither, 01 own, 10 far |
| cyc_addr | input | 2xAW | Cycle address per side |
| cyc_cmd | input | 2xCW | Cycle command per side |
| cyc_post | input | 2 | Cycle may be posted |
| peer_devsel | input | 2 | Another device on that bus already claimed it |
| fwd_done | input | 2 | Forwarded delayed cycle finished on the far bus |
| devsel | output | 2 | Bridge claims the cycle |
| trm_ok | output | 2 | Normal termination |
| trm_retry | output | 2 | Retry termination |
| trm_none | output | 2 | Bridge does not respond |
| mabort | output | 1 | Primary cycle to no target will master-abort |
| fwd_req | output | 2 | Forward request toward the opposite bus |
| fwd_posted | output | 2 | Forwarded cycle is posted |
| fwd_addr | output | 2xAW | Forwarded address |
| fwd_cmd | output | 2xCW | Forwarded command |

## Verification
A slot stuck busy shows at the first non-postable crossing cycle: it returns a retry and sends no forward, where a free slot would forward. A slot freed too early, or one that matches the wrong fields, shows on the next repeat as the wrong one of ok or retry. A location or peer decode fault shows as a wrong devsel or termination code in the very next cycle. The scenario therefore orders its repeats so that each slot state is probed right after the event that should change it.

// File: rtl/xbc_pkg.sv
package xbc_pkg;
   typedef enum logic [1:0] {
      LOC_NONE = 2'b00,
      LOC_OWN  = 2'b01,
      LOC_FAR  = 2'b10
   } loc_e;

   typedef enum logic [1:0] {
      DT_IDLE  = 2'd0,
      DT_WAIT  = 2'd1,
      DT_READY = 2'd2
   } dt_st_e;

   typedef enum logic [1:0] {
      TRM_NONE  = 2'd0,
      TRM_OK    = 2'd1,
      TRM_RETRY = 2'd2
   } trm_e;
endpackage

// File: rtl/xbc_dly_entry.sv
module xbc_dly_entry
   import xbc_pkg::*;
#(
   parameter int AW        = 16,
   parameter int CW        = 4,
   parameter bit MATCH_CMD = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cap,
   input  logic [AW-1:0] cap_addr,
   input  logic [CW-1:0] cap_cmd,
   input  logic          far_done,
   input  logic          rel,
   input  logic [AW-1:0] probe_addr,
   input  logic [CW-1:0] probe_cmd,
   output logic          is_idle,
   output logic          is_ready,
   output logic          hit
);
   dt_st_e        st_q;
   logic [AW-1:0] addr_q;
   logic [CW-1:0] cmd_q;
   logic          addr_eq;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= DT_IDLE;
         addr_q <= '0;
         cmd_q  <= '0;
      end else begin
         unique case (st_q)
            DT_IDLE: if (cap) begin
               st_q   <= DT_WAIT;
               addr_q <= cap_addr;
               cmd_q  <= cap_cmd;
            end
            DT_WAIT:  if (far_done) st_q <= DT_READY;
            DT_READY: if (rel) st_q <= DT_IDLE;
            default:  st_q <= DT_IDLE;
         endcase
      end
   end

   assign is_idle  = (st_q == DT_IDLE);
   assign is_ready = (st_q == DT_READY);
   assign addr_eq  = (probe_addr == addr_q);

   generate
      if (MATCH_CMD) begin : g_full_match
         assign hit = addr_eq && (probe_cmd == cmd_q);
      end else begin : g_addr_match
         assign hit = addr_eq;
      end
   endgenerate

   // R4: a capture only lands in a free slot
   assert_cap_free_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cap |-> is_idle);
   // R6: release only after far-side completion, and it frees the slot
   assert_rel_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rel |-> is_ready);
   assert_rel_frees_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rel |=> is_idle);
   // R12: completion while free is ignored
   assert_done_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (far_done && is_idle && !cap) |=> is_idle);
endmodule

// File: rtl/xbc_side_claim.sv
module xbc_side_claim
   import xbc_pkg::*;
#(
   parameter int AW        = 16,
   parameter int CW        = 4,
   parameter bit MATCH_CMD = 1'b1,
   parameter bit ABORT_EN  = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          vld,
   input  logic [1:0]    loc,
   input  logic [AW-1:0] addr,
   input  logic [CW-1:0] cmd,
   input  logic          post,
   input  logic          peer,
   input  logic          far_done,
   output logic          devsel_o,
   output logic          ok_o,
   output logic          retry_o,
   output logic          none_o,
   output logic          mab_o,
   output logic          fwd_o,
   output logic          fwd_post_o,
   output logic [AW-1:0] fwd_addr_o,
   output logic [CW-1:0] fwd_cmd_o
);
   logic   claim, cap, rel, fwd_d, fwd_post_d, mab_d;
   logic   slot_idle, slot_ready, slot_hit;
   trm_e   trm_d;

   xbc_dly_entry #(.AW(AW), .CW(CW), .MATCH_CMD(MATCH_CMD)) slot_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .cap        (cap),
      .cap_addr   (addr),
      .cap_cmd    (cmd),
      .far_done   (far_done),
      .rel        (rel),
      .probe_addr (addr),
      .probe_cmd  (cmd),
      .is_idle    (slot_idle),
      .is_ready   (slot_ready),
      .hit        (slot_hit)
   );

   assign claim = vld && (loc == LOC_FAR) && !peer;

   always_comb begin
      trm_d      = TRM_NONE;
      cap        = 1'b0;
      rel        = 1'b0;
      fwd_d      = 1'b0;
      fwd_post_d = 1'b0;
      if (claim) begin
         if (post) begin
            trm_d      = TRM_OK;
            fwd_d      = 1'b1;
            fwd_post_d = 1'b1;
         end else if (slot_idle) begin
            trm_d = TRM_RETRY;
            cap   = 1'b1;
            fwd_d = 1'b1;
         end else if (slot_ready && slot_hit) begin
            trm_d = TRM_OK;
            rel   = 1'b1;
         end else begin
            trm_d = TRM_RETRY;
         end
      end
   end

   generate
      if (ABORT_EN) begin : g_abort
         assign mab_d = vld && (loc == LOC_NONE) && !peer;
      end else begin : g_no_abort
         assign mab_d = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         devsel_o   <= 1'b0;
         ok_o       <= 1'b0;
         retry_o    <= 1'b0;
         none_o     <= 1'b0;
         mab_o      <= 1'b0;
         fwd_o      <= 1'b0;
         fwd_post_o <= 1'b0;
         fwd_addr_o <= '0;
         fwd_cmd_o  <= '0;
      end else begin
         devsel_o   <= claim;
         ok_o       <= (trm_d == TRM_OK);
         retry_o    <= (trm_d == TRM_RETRY);
         none_o     <= vld && !claim;
         mab_o      <= mab_d;
         fwd_o      <= fwd_d;
         fwd_post_o <= fwd_post_d;
         if (fwd_d) begin
            fwd_addr_o <= addr;
            fwd_cmd_o  <= cmd;
         end
      end
   end

   // R11: exactly one termination after a strobe, silence otherwise
   assert_trm_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
      vld |=> ($countones({ok_o, retry_o, none_o}) == 1));
   assert_trm_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !vld |=> !(ok_o || retry_o || none_o));
   // R1 / R2: device select accompanies a response
   assert_devsel_resp_R1: assert property (@(posedge clk) disable iff (!rst_n)
      devsel_o |-> !none_o);
   // R8: own-side target gets no response
   assert_own_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (vld && loc == LOC_OWN) |=> (none_o && !devsel_o && !fwd_o));
   // R10: a peer claim keeps the bridge off the cycle
   assert_peer_yield_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (vld && peer) |=> (none_o && !fwd_o && !mab_o));
   // R3 / R4: posted forwards complete, delayed forwards retry
   assert_fwd_post_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (fwd_o && fwd_post_o) |-> ok_o);
   assert_fwd_delay_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (fwd_o && !fwd_post_o) |-> retry_o);
   // R9: master abort only with no response
   assert_mab_none_R9: assert property (@(posedge clk) disable iff (!rst_n)
      mab_o |-> none_o);
endmodule

// File: rtl/xbc_claim_top.sv
module xbc_claim_top
   import xbc_pkg::*;
#(
   parameter int AW        = 16,
   parameter int CW        = 4,
   parameter bit MATCH_CMD = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [1:0]          cyc_vld,
   input  logic [1:0][1:0]     cyc_loc,
   input  logic [1:0][AW-1:0]  cyc_addr,
   input  logic [1:0][CW-1:0]  cyc_cmd,
   input  logic [1:0]          cyc_post,
   input  logic [1:0]          peer_devsel,
   input  logic [1:0]          fwd_done,
   output logic [1:0]          devsel,
   output logic [1:0]          trm_ok,
   output logic [1:0]          trm_retry,
   output logic [1:0]          trm_none,
   output logic                mabort,
   output logic [1:0]          fwd_req,
   output logic [1:0]          fwd_posted,
   output logic [1:0][AW-1:0]  fwd_addr,
   output logic [1:0][CW-1:0]  fwd_cmd
);
   localparam int NSIDE = 2;
   localparam int PRI   = 0;

   logic [NSIDE-1:0] mab_side;

   generate
      if (AW < 2) begin : g_bad_aw
         $error("xbc_claim_top: AW must be at least 2");
      end
      if (CW < 1) begin : g_bad_cw
         $error("xbc_claim_top: CW must be at least 1");
      end

      for (genvar s = 0; s < NSIDE; s++) begin : g_side
         xbc_side_claim #(
            .AW        (AW),
            .CW        (CW),
            .MATCH_CMD (MATCH_CMD),
            .ABORT_EN  (s == PRI)
         ) side_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .vld        (cyc_vld[s]),
            .loc        (cyc_loc[s]),
            .addr       (cyc_addr[s]),
            .cmd        (cyc_cmd[s]),
            .post       (cyc_post[s]),
            .peer       (peer_devsel[s]),
            .far_done   (fwd_done[s]),
            .devsel_o   (devsel[s]),
            .ok_o       (trm_ok[s]),
            .retry_o    (trm_retry[s]),
            .none_o     (trm_none[s]),
            .mab_o      (mab_side[s]),
            .fwd_o      (fwd_req[s]),
            .fwd_post_o (fwd_posted[s]),
            .fwd_addr_o (fwd_addr[s]),
            .fwd_cmd_o  (fwd_cmd[s])
         );
      end
   endgenerate

   assign mabort = mab_side[PRI];

   // R9: the secondary side never flags master abort
   assert_sec_no_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !mab_side[1]);
   // R2: a secondary claim does not disturb the primary response
   assert_sides_apart_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_vld[1] && !cyc_vld[0]) |=> !(trm_ok[0] || trm_retry[0] || trm_none[0]));
endmodule

// File: tb/xbc_claim_top_tb_top.sv
module xbc_claim_top_tb_top;
   localparam int AW = 16;
   localparam int CW = 4;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic [1:0]         cyc_vld = '0;
   logic [1:0][1:0]    cyc_loc = '0;
   logic [1:0][AW-1:0] cyc_addr = '0;
   logic [1:0][CW-1:0] cyc_cmd = '0;
   logic [1:0]         cyc_post = '0;
   logic [1:0]         peer_devsel = '0;
   logic [1:0]         fwd_done = '0;
   logic [1:0]         devsel, trm_ok, trm_retry, trm_none, fwd_req, fwd_posted;
   logic               mabort;
   logic [1:0][AW-1:0] fwd_addr;
   logic [1:0][CW-1:0] fwd_cmd;

   always #2 clk = ~clk;

   xbc_claim_top #(.AW(AW), .CW(CW)) dut_i (
      .clk(clk), .rst_n(rst_n), .cyc_vld(cyc_vld), .cyc_loc(cyc_loc),
      .cyc_addr(cyc_addr), .cyc_cmd(cyc_cmd), .cyc_post(cyc_post),
      .peer_devsel(peer_devsel), .fwd_done(fwd_done), .devsel(devsel),
      .trm_ok(trm_ok), .trm_retry(trm_retry), .trm_none(trm_none),
      .mabort(mabort), .fwd_req(fwd_req), .fwd_posted(fwd_posted),
      .fwd_addr(fwd_addr), .fwd_cmd(fwd_cmd)
   );

   typedef struct packed {
      logic          side;
      logic [1:0]    trm;
      logic          dev;
      logic          fwd;
      logic          post;
      logic          ab;
      logic [AW-1:0] addr;
      logic [CW-1:0] cmd;
   } exp_t;

   exp_t  expq[$];
   string tagq[$];
   int    n_vec = 0;
   int    n_bad = 0;
   bit    mon_on = 1'b0;
   bit    finished = 1'b0;

   int            m_st[2];
   logic [AW-1:0] m_addr[2];
   logic [CW-1:0] m_cmd[2];

   task automatic miss(string tag, string what, int act, int exp);
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
   endtask

   task automatic issue(input int s, input logic [1:0] loc, input logic [AW-1:0] a,
                        input logic [CW-1:0] c, input logic p, input logic pr,
                        input string tag);
      exp_t e;
      e = '0;
      e.side = s[0];
      e.addr = a;
      e.cmd  = c;
      if (loc == 2'b10 && !pr) begin
         e.dev = 1'b1;
         if (p) begin
            e.trm = 2'd1; e.fwd = 1'b1; e.post = 1'b1;
         end else if (m_st[s] == 0) begin
            e.trm = 2'd2; e.fwd = 1'b1;
            m_st[s] = 1; m_addr[s] = a; m_cmd[s] = c;
         end else if (m_st[s] == 2 && a == m_addr[s] && c == m_cmd[s]) begin
            e.trm = 2'd1; m_st[s] = 0;
         end else begin
            e.trm = 2'd2;
         end
      end else begin
         e.trm = 2'd0;
         e.ab  = (s == 0) && (loc == 2'b00) && !pr;
      end
      @(negedge clk);
      cyc_vld[s] = 1'b1; cyc_loc[s] = loc; cyc_addr[s] = a;
      cyc_cmd[s] = c; cyc_post[s] = p; peer_devsel[s] = pr;
      expq.push_back(e);
      tagq.push_back(tag);
      @(negedge clk);
      cyc_vld = '0; peer_devsel = '0; cyc_post = '0;
   endtask

   task automatic done(input int s);
      if (m_st[s] == 1) m_st[s] = 2;
      @(negedge clk);
      fwd_done[s] = 1'b1;
      @(negedge clk);
      fwd_done = '0;
   endtask

   task automatic check_idle(input int s, input string tag);
      if (trm_ok[s] || trm_retry[s] || trm_none[s])
         miss(tag, "idle terms", {trm_ok[s], trm_retry[s], trm_none[s]}, 0);
      if (devsel[s]) miss(tag, "idle devsel", 1, 0);
      if (fwd_req[s]) miss(tag, "idle fwd", 1, 0);
      if (s == 0 && mabort) miss(tag, "idle mabort", 1, 0);
   endtask

   // monitor: compares design results against the queued expectations
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (mon_on) begin
            if (expq.size() > 0) begin
               exp_t  e;
               string t;
               int    s;
               logic [2:0] got, want;
               e = expq.pop_front();
               t = tagq.pop_front();
               s = int'(e.side);
               n_vec++;
               got  = {trm_ok[s], trm_retry[s], trm_none[s]};
               want = (e.trm == 2'd1) ? 3'b100 : (e.trm == 2'd2) ? 3'b010 : 3'b001;
               if (got != want) miss(t, "termination", got, want);
               if (devsel[s] != e.dev) miss(t, "devsel", devsel[s], e.dev);
               if (fwd_req[s] != e.fwd) miss(t, "fwd_req", fwd_req[s], e.fwd);
               if (e.fwd && fwd_posted[s] != e.post) miss(t, "fwd_posted", fwd_posted[s], e.post);
               if (e.fwd && fwd_addr[s] != e.addr) miss(t, "fwd_addr", fwd_addr[s], e.addr);
               if (e.fwd && fwd_cmd[s] != e.cmd) miss(t, "fwd_cmd", fwd_cmd[s], e.cmd);
               if (mabort != e.ab) miss(t, "mabort", mabort, e.ab);
               check_idle(1 - s, {t, " other side"});
            end else begin
               check_idle(0, "R11");
               check_idle(1, "R11");
            end
         end
      end
   end

   initial begin
      #(200000 * 4);
      if (!finished) begin
         finished = 1'b1;
         n_bad++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      m_st[0] = 0; m_st[1] = 0;
      repeat (3) @(negedge clk);
      // R12: reset state
      n_vec++;
      if ({devsel, trm_ok, trm_retry, trm_none, fwd_req, mabort} != '0)
         miss("R12", "reset outputs", {devsel, trm_ok, trm_retry, trm_none, fwd_req}, 0);
      rst_n = 1'b1;
      mon_on = 1'b1;
      @(negedge clk);

      issue(0, 2'b10, 16'h1000, 4'h7, 1'b1, 1'b0, "R1");
      issue(1, 2'b10, 16'h2004, 4'h7, 1'b1, 1'b0, "R2");
      issue(0, 2'b10, 16'h0040, 4'h6, 1'b0, 1'b0, "R4");
      issue(0, 2'b10, 16'h0040, 4'h6, 1'b0, 1'b0, "R5");
      issue(0, 2'b10, 16'h0080, 4'hA, 1'b0, 1'b0, "R5");
      issue(0, 2'b10, 16'h3000, 4'h7, 1'b1, 1'b0, "R3");
      done(0);
      issue(0, 2'b10, 16'h0040, 4'hA, 1'b0, 1'b0, "R7");
      issue(0, 2'b10, 16'h0044, 4'h6, 1'b0, 1'b0, "R7");
      issue(0, 2'b10, 16'h0040, 4'h6, 1'b0, 1'b0, "R6");
      issue(0, 2'b10, 16'h0100, 4'hC, 1'b0, 1'b0, "R6");
      issue(0, 2'b01, 16'h5000, 4'h6, 1'b0, 1'b0, "R8");
      issue(1, 2'b01, 16'h5000, 4'h6, 1'b1, 1'b0, "R8");
      issue(0, 2'b00, 16'h6000, 4'h6, 1'b0, 1'b0, "R9");
      issue(1, 2'b00, 16'h6000, 4'h6, 1'b0, 1'b0, "R9");
      issue(0, 2'b10, 16'h7000, 4'h7, 1'b1, 1'b1, "R10");
      issue(1, 2'b10, 16'h7000, 4'h6, 1'b0, 1'b1, "R10");
      issue(0, 2'b00, 16'h7004, 4'h6, 1'b0, 1'b1, "R10");
      done(1);
      issue(1, 2'b10, 16'h0200, 4'hE, 1'b0, 1'b0, "R12");
      issue(1, 2'b10, 16'h0200, 4'hE, 1'b0, 1'b0, "R5");
      done(1);
      issue(1, 2'b10, 16'h0200, 4'hF, 1'b0, 1'b0, "R7");
      issue(1, 2'b10, 16'h0200, 4'hE, 1'b0, 1'b0, "R6");
      issue(1, 2'b10, 16'h0300, 4'h6, 1'b0, 1'b0, "R2");
      done(0);
      issue(0, 2'b10, 16'h0100, 4'hC, 1'b0, 1'b0, "R6");
      repeat (3) @(negedge clk);

      if (!finished) begin
         finished = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule